// File: doc/BRIEF.md
# Flash erase command sequencer

This block takes erase and program commands from a small register write port and runs them one at a time against a built-in model of a flash array. Software fills a control register with its choices: whole-array erase, single-sector erase, a sector number and program-enable. It sets the start bit in that same write. For a program it first loads a word address and a data value into two staging registers. While an operation runs, the `busy` output stays high. Software is expected to wait for `busy` to fall before it issues the next command.

The sequencer checks the command at the moment start is seen. If exactly one erase select is set, the erase is issued to the core model. If program-enable is set as well, the program runs after the erase completes. When both erase selects are set, no erase takes place. A start that arrives while an operation is running is dropped, and a sticky error flag is raised. The core model sets erased words to all ones. A program can only clear bits, so each word is ANDed with the staged data. Each operation finishes after a cycle count set by a parameter, and the core then returns a done pulse.

A combinational read port into the model array lets the surrounding logic see the result of every operation.

Top module: `flash_erase_seq`

## Requirements
- R1: `busy` rises two cycles after the write that starts an accepted operation. It stays high for ERASE_CYC+2 cycles for an erase and PROG_CYC+2 cycles for a program. It falls only after the core has reported done.
- R2: A control write (`wr_sel`=0) with bit 0 (whole-array) set, bit 1 (sector) clear and bit 3 (start) set sets every word of the array to all ones.
- R3: A control write with bit 1 set, bit 0 clear and bit 3 set sets to all ones only the WPS words of the sector given in bits 8 and up. The words of sector s are addresses s*WPS to s*WPS+WPS-1. All other words keep their contents.
- R4: If bits 0 and 1 are both set when start is seen, no erase of any kind is performed. With program-enable (bit 2) clear, `busy` stays low. With bit 2 set, only the program runs.
- R5: When one start requests an erase (exactly one select set) and a program (bit 2), the erase is done first and the program follows. The programmed word ends up as all-ones AND data, and `busy` stays high for ERASE_CYC+PROG_CYC+4 cycles without a gap.
- R6: A start with only bit 2 set programs the word at the staged address (`wr_sel`=1) with the staged data (`wr_sel`=2). The new word is old AND data, so no bit can go from 0 to 1.
- R7: A start seen while `busy` is high is ignored, with no extra operation and no change to the array beyond the running one. It sets `seq_err`, which stays set until reset.
- R8: A start with bits 0, 1 and 2 all clear does nothing, and `busy` stays low.
- R9: The sector number is captured when start is seen. Rewriting the control register during a sector erase does not change which sector is erased.
- R10: Start acts once. After an operation ends, no further operation runs until another write sets bit 3, even if the other control bits are left set.
- R11: After reset, `busy` and `seq_err` are low and every array word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 program address, 2 program data |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Array word address to read |
| rd_data | output | DW | Array word contents |
| busy | output | 1 | High while an erase or program is in progress |
| seq_err | output | 1 | Sticky flag for a start seen while busy |

## Verification
Two functions can fall on the same start: an erase and a program. The bench provokes this with control writes that set an erase select together with program-enable. It stages the program address inside the sector being erased, so the wrong order would leave the word all ones. The bench also makes a start collide with a running operation by writing start again while `busy` is high. It then judges from the array contents and the `busy` duration that only the first command ran, and that `seq_err` was raised.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ERASE = 2'd1,
      ST_PROG  = 2'd2
   } fes_state_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_MASS = 2'd1,
      OP_SECT = 2'd2,
      OP_PROG = 2'd3
   } fes_op_e;

   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_PADDR = 2'd1;
   localparam logic [1:0] SEL_PDATA = 2'd2;

   localparam int CB_WHOLE = 0;
   localparam int CB_SECT  = 1;
   localparam int CB_PGM   = 2;
   localparam int CB_START = 3;
   localparam int CB_SNUM  = 8;

endpackage

// File: rtl/fes_regs.sv
module fes_regs
   import fes_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4,
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [31:0]   wr_data,
   output logic          whole_sel,
   output logic          sect_sel,
   output logic          pgm_en,
   output logic [SW-1:0] snum,
   output logic [AW-1:0] paddr,
   output logic [DW-1:0] pdata,
   output logic          start_p
);

   logic ctrl_wr;
   logic unused_wr;

   assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         whole_sel <= 1'b0;
         sect_sel  <= 1'b0;
         pgm_en    <= 1'b0;
         snum      <= '0;
         paddr     <= '0;
         pdata     <= '0;
         start_p   <= 1'b0;
      end else begin
         start_p <= ctrl_wr && wr_data[CB_START];
         if (ctrl_wr) begin
            whole_sel <= wr_data[CB_WHOLE];
            sect_sel  <= wr_data[CB_SECT];
            pgm_en    <= wr_data[CB_PGM];
            snum      <= wr_data[CB_SNUM +: SW];
         end
         if (wr_en && (wr_sel == SEL_PADDR)) paddr <= wr_data[AW-1:0];
         if (wr_en && (wr_sel == SEL_PDATA)) pdata <= wr_data[DW-1:0];
      end
   end

endmodule

// File: rtl/fes_seq.sv
module fes_seq
   import fes_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4,
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_p,
   input  logic          whole_sel,
   input  logic          sect_sel,
   input  logic          pgm_en,
   input  logic [SW-1:0] snum,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pdata,
   input  logic          core_done,
   output logic          busy,
   output logic          seq_err,
   output logic          core_req,
   output fes_op_e       core_op,
   output logic [SW-1:0] op_sector,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);

   fes_state_e state;
   logic       prog_pend;
   logic       erase_ok;

   assign erase_ok = whole_sel ^ sect_sel;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         prog_pend <= 1'b0;
         seq_err   <= 1'b0;
         core_req  <= 1'b0;
         core_op   <= OP_NONE;
         op_sector <= '0;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         core_req <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_p) begin
                  op_addr <= paddr;
                  op_data <= pdata;
                  if (erase_ok) begin
                     core_op   <= whole_sel ? OP_MASS : OP_SECT;
                     op_sector <= snum;
                     prog_pend <= pgm_en;
                     core_req  <= 1'b1;
                     state     <= ST_ERASE;
                  end else if (pgm_en) begin
                     core_op  <= OP_PROG;
                     core_req <= 1'b1;
                     state    <= ST_PROG;
                  end
               end
            end
            ST_ERASE: begin
               if (start_p) seq_err <= 1'b1;
               if (core_done) begin
                  if (prog_pend) begin
                     prog_pend <= 1'b0;
                     core_op   <= OP_PROG;
                     core_req  <= 1'b1;
                     state     <= ST_PROG;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_PROG: begin
               if (start_p) seq_err <= 1'b1;
               if (core_done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fes_core.sv
module fes_core
   import fes_pkg::*;
#(
   parameter int DW        = 8,
   parameter int NSECT     = 4,
   parameter int WPS       = 4,
   parameter int ERASE_CYC = 6,
   parameter int PROG_CYC  = 3,
   localparam int NWORDS   = NSECT * WPS,
   localparam int AW       = $clog2(NWORDS),
   localparam int SW       = $clog2(NSECT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  fes_op_e       op,
   input  logic [SW-1:0] sector,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          active,
   output logic          done
);

   localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0]          cnt;
   fes_op_e                op_q;
   logic [SW-1:0]          sect_q;
   logic [AW-1:0]          addr_q;
   logic [DW-1:0]          data_q;
   logic                   apply;
   logic [NWORDS-1:0][DW-1:0] words;

   assign apply   = active && (cnt == '0);
   assign rd_data = words[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         cnt    <= '0;
         op_q   <= OP_NONE;
         sect_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         done <= 1'b0;
         if (req && !active) begin
            active <= 1'b1;
            op_q   <= op;
            sect_q <= sector;
            addr_q <= addr;
            data_q <= data;
            cnt    <= (op == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
         end else if (active) begin
            if (cnt == '0) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
      localparam int SEC = gi / WPS;
      logic [DW-1:0] word_q;
      logic          hit_erase;
      logic          hit_prog;

      assign hit_erase = apply && ((op_q == OP_MASS) ||
                         ((op_q == OP_SECT) && (sect_q == SW'(SEC))));
      assign hit_prog  = apply && (op_q == OP_PROG) && (addr_q == AW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         word_q <= '0;
         else if (hit_erase) word_q <= {DW{1'b1}};
         else if (hit_prog)  word_q <= word_q & data_q;
      end

      assign words[gi] = word_q;
   end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int DW        = 8,
   parameter int NSECT     = 4,
   parameter int WPS       = 4,
   parameter int ERASE_CYC = 6,
   parameter int PROG_CYC  = 3,
   localparam int NWORDS   = NSECT * WPS,
   localparam int AW       = $clog2(NWORDS),
   localparam int SW       = $clog2(NSECT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [31:0]   wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          seq_err
);

   if (NSECT < 2 || (1 << SW) != NSECT)
      $error("NSECT must be a power of two, at least 2");
   if (WPS < 1 || NWORDS != (1 << AW))
      $error("NSECT*WPS must be a power of two");
   if (SW > 8)
      $error("sector field wider than 8 bits");
   if (DW < 1 || DW > 32)
      $error("DW must lie in 1..32");
   if (ERASE_CYC < 1 || PROG_CYC < 1)
      $error("operation cycle counts must be at least 1");

   logic          whole_sel, sect_sel, pgm_en, start_p;
   logic [SW-1:0] snum, op_sector;
   logic [AW-1:0] paddr, op_addr;
   logic [DW-1:0] pdata, op_data;
   logic          core_req, core_done, core_active;
   fes_op_e       core_op;

   fes_regs #(.DW(DW), .AW(AW), .SW(SW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .whole_sel(whole_sel), .sect_sel(sect_sel),
      .pgm_en(pgm_en), .snum(snum), .paddr(paddr), .pdata(pdata),
      .start_p(start_p)
   );

   fes_seq #(.DW(DW), .AW(AW), .SW(SW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .whole_sel(whole_sel),
      .sect_sel(sect_sel), .pgm_en(pgm_en), .snum(snum), .paddr(paddr),
      .pdata(pdata), .core_done(core_done), .busy(busy), .seq_err(seq_err),
      .core_req(core_req), .core_op(core_op), .op_sector(op_sector),
      .op_addr(op_addr), .op_data(op_data)
   );

   fes_core #(.DW(DW), .NSECT(NSECT), .WPS(WPS), .ERASE_CYC(ERASE_CYC),
              .PROG_CYC(PROG_CYC)) u_core (
      .clk(clk), .rst_n(rst_n), .req(core_req), .op(core_op),
      .sector(op_sector), .addr(op_addr), .data(op_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .active(core_active),
      .done(core_done)
   );

endmodule

// File: rtl/fes_check.sv
module fes_check #(
   parameter int SW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          seq_err,
   input logic          start_p,
   input logic          core_req,
   input logic          core_active,
   input logic          core_done,
   input logic [SW-1:0] op_sector
);

   // R1: the core never works outside a busy window
   a_r1_core_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      core_active |-> busy);

   // R1: busy drops only right after the core reports done
   a_r1_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(core_done));

   // R5: a new request never lands on a core that is still working
   a_r5_req_on_free_core: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> !core_active);

   // R7: a start during busy raises the error flag
   a_r7_err_on_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_p && busy) |=> seq_err);

   // R7: the error flag holds until reset
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   // R9: captured sector does not move while the core works
   a_r9_sector_stable: assert property (@(posedge clk) disable iff (!rst_n)
      core_active |-> $stable(op_sector));

endmodule

bind flash_erase_seq fes_check #(.SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .seq_err(seq_err),
   .start_p(start_p), .core_req(core_req), .core_active(core_active),
   .core_done(core_done), .op_sector(op_sector)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int NS   = 4;
   localparam int WPS  = 4;
   localparam int EC   = 6;
   localparam int PC   = 3;
   localparam int NW   = NS * WPS;
   localparam int AW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;
   logic          seq_err;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] expm [NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_erase_seq #(.DW(DW), .NSECT(NS), .WPS(WPS), .ERASE_CYC(EC),
                     .PROG_CYC(PC)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .seq_err(seq_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NW; i++) expm[i] = '0;
   endtask

   task automatic wait_op(output int n);
      n = 0;
      for (int g = 0; g < 400; g++) begin
         @(negedge clk);
         if (busy) n++;
         else if (n > 0) break;
      end
   endtask

   task automatic busy_cycles(input int len, output int n);
      n = 0;
      for (int g = 0; g < len; g++) begin
         @(negedge clk);
         if (busy) n++;
      end
   endtask

   task automatic check_array(input string req);
      for (int i = 0; i < NW; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(rd_data === expm[i], req, int'(rd_data), int'(expm[i]));
      end
   endtask

   task automatic program_word(input int a, input logic [DW-1:0] d, input string req);
      int n;
      wr(2'd1, 32'(a));
      wr(2'd2, 32'(d));
      wr(2'd0, 32'h0000_000C);
      wait_op(n);
      chk(n == PC + 2, req, n, PC + 2);
      expm[a] = expm[a] & d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      // R11 reset state
      @(negedge clk);
      chk(busy == 1'b0, "R11 busy", int'(busy), 0);
      chk(seq_err == 1'b0, "R11 seq_err", int'(seq_err), 0);
      check_array("R11 array");

      // R2 whole-array erase, R1 duration
      wr(2'd0, 32'h0000_0009);
      wait_op(n);
      chk(n == EC + 2, "R1 erase busy length", n, EC + 2);
      for (int i = 0; i < NW; i++) expm[i] = '1;
      check_array("R2 whole erase");

      // R6 program sweep, one bit cleared per word
      for (int i = 0; i < NW; i++)
         program_word(i, ~(DW'(1) << (i % DW)), "R6 program length");
      program_word(3, 8'hF0, "R6 reprogram length");
      check_array("R6 program only clears bits");

      // R3 sector erase sweep
      for (int s = 0; s < NS; s++) begin
         wr(2'd0, 32'h0000_000A | (32'(s) << 8));
         wait_op(n);
         chk(n == EC + 2, "R3 sector busy length", n, EC + 2);
         for (int w = 0; w < WPS; w++) expm[s*WPS + w] = '1;
         check_array("R3 sector erase");
         program_word(s*WPS + 2, 8'h00, "R3 reprogram");
      end

      // R4 both erase selects, no program
      wr(2'd0, 32'h0000_0003 | 32'h8);
      busy_cycles(20, n);
      chk(n == 0, "R4 conflict busy", n, 0);
      check_array("R4 conflict no erase");
      // R4 both selects with program enabled: program only
      wr(2'd1, 32'd5);
      wr(2'd2, 32'h0000_000F);
      wr(2'd0, 32'h0000_000F);
      wait_op(n);
      chk(n == PC + 2, "R4 conflict program length", n, PC + 2);
      expm[5] = expm[5] & 8'h0F;
      check_array("R4 conflict program only");

      // R8 start with nothing selected
      wr(2'd0, 32'h0000_0008);
      busy_cycles(20, n);
      chk(n == 0, "R8 empty start busy", n, 0);
      check_array("R8 empty start");

      // R5 erase and program on one start
      wr(2'd1, 32'd2);
      wr(2'd2, 32'h0000_003C);
      wr(2'd0, 32'h0000_000D);
      wait_op(n);
      chk(n == EC + PC + 4, "R5 whole+prog length", n, EC + PC + 4);
      for (int i = 0; i < NW; i++) expm[i] = '1;
      expm[2] = 8'h3C;
      check_array("R5 erase then program");
      for (int s = 0; s < NS; s++) begin
         program_word(s*WPS + 1, 8'h00, "R5 prep");
         wr(2'd1, 32'(s*WPS + 1));
         wr(2'd2, 32'(8'h5A ^ DW'(s)));
         wr(2'd0, 32'h0000_000E | (32'(s) << 8));
         wait_op(n);
         chk(n == EC + PC + 4, "R5 sector+prog length", n, EC + PC + 4);
         for (int w = 0; w < WPS; w++) expm[s*WPS + w] = '1;
         expm[s*WPS + 1] = 8'h5A ^ DW'(s);
         check_array("R5 sector erase then program");
      end

      // R9 sector captured at start
      for (int i = 0; i < NW; i++) program_word(i, 8'h00, "R9 prep");
      wr(2'd0, 32'h0000_010A);
      wr(2'd0, 32'h0000_0302);
      wait_op(n);
      chk(n > 0, "R9 erase ran", n, 1);
      for (int w = 0; w < WPS; w++) expm[WPS + w] = '1;
      check_array("R9 sector held");

      // R10 start acts once
      busy_cycles(30, n);
      chk(n == 0, "R10 no rerun", n, 0);
      check_array("R10 array unchanged");

      // R7 start while busy
      chk(seq_err == 1'b0, "R7 err before", int'(seq_err), 0);
      wr(2'd0, 32'h0000_000A);
      wr(2'd0, 32'h0000_0009);
      wait_op(n);
      for (int w = 0; w < WPS; w++) expm[w] = '1;
      check_array("R7 second start ignored");
      chk(seq_err == 1'b1, "R7 err set", int'(seq_err), 1);
      busy_cycles(20, n);
      chk(n == 0, "R7 no queued op", n, 0);
      chk(seq_err == 1'b1, "R7 err sticky", int'(seq_err), 1);

      do_reset();
      @(negedge clk);
      chk(seq_err == 1'b0, "R11 err cleared by reset", int'(seq_err), 0);
      check_array("R11 array after reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule